// File: doc/BRIEF.md
# Reversible 5/3 Wavelet Engine for a Square Tile

This block applies a multi-level, exactly invertible, integer-only two-dimensional wavelet transform to one square image tile. The tile lives in a single on-chip RAM that the block owns. Software or an upstream stage writes the tile through a load port. A start strobe launches the transform. When the block raises a one-cycle done pulse, the coefficients can be fetched through a readout port. The transform replaces the samples where they sit, so no second tile-sized store is needed.

Each decomposition level transforms every row of the active square and then every column of it. A line is streamed out of the RAM once. The lifting filter runs while the samples arrive, reusing values it already holds instead of fetching them again. A de-interleave stage then writes the line back with all low-pass results first and all high-pass results after them. Each later level works only on the top-left quarter (the low-low band) left by the level before. With three levels the tile ends up holding LL3, HL3, LH3 and HH3 in the corner, surrounded by the detail bands of level 2 and then level 1.

Top module: `dwt_tile_engine`

## Requirements
- R1: After reset, `busy` and `done` are both low.
- R2: While `busy` is low, a cycle with `loadEn` high stores `loadData` at `loadAddr`. The address is row*TILE+column. `rdData` returns the word at `rdAddr` one clock after `rdAddr` is presented.
- R3: A `start` strobe taken while both `busy` and `done` are low raises `busy` on the next clock. A `start` strobe given while `busy` is high has no effect: the run keeps its length and gives one `done` pulse.
- R4: Each 1D pass over a line x[0..n-1] computes d[m] = x[2m+1] - floor((x[2m]+x[2m+2])/2) and s[m] = x[2m] + floor((d[m-1]+d[m]+2)/4). Both use symmetric borders: x[n] is taken as x[n-2], and d[-1] is taken as d[0].
- R5: A pass writes s[0..n/2-1] back to positions 0..n/2-1 of the line and d[0..n/2-1] to positions n/2..n-1. Each level transforms all rows first and then all columns.
- R6: Level k (k = 0..LEVELS-1) works only on the top-left (TILE>>k)-square. Data outside that square keeps the value written by the earlier levels.
- R7: `done` is high for exactly one cycle. It comes right after the final column pass writes its last coefficient, with `busy` low in that cycle. `busy` falls only into a `done` cycle.
- R8: The transform is exactly reversible. Running the inverse lifting steps, level by level in reverse order, on the readout returns the loaded tile bit for bit. This holds for inputs in the range -1000..1000, which keep every coefficient within 16 signed bits.
- R9: `loadEn` pulses during a run do not change the tile memory.
- R10: A run keeps `busy` high for exactly the sum over levels of 2n(2n+1) cycles, where n = TILE>>level. Each line costs n read cycles, one drain cycle and n write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write strobe for the tile load port |
| loadAddr | input | 2*log2(TILE) | Load address, row*TILE+column |
| loadData | input | DATA_W | Sample to store, two's complement |
| start | input | 1 | Launch the transform |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| rdAddr | input | 2*log2(TILE) | Readout address, row*TILE+column |
| rdData | output | DATA_W | Word at the previous cycle's rdAddr |

## Verification
The bench builds the engine with TILE=32, DATA_W=16 and LEVELS=3. The lines it transforms are therefore 32, 16 and 8 samples long, and the final tile holds the complete three-level band arrangement. A constant tile, a full-swing checkerboard and a corner impulse push the symmetric border rules and the largest coefficient growth through every level. Random tiles fill the interior. The three level sizes make the exact busy length a sharp check on how lines are ordered and counted. Stray start and load strobes are injected in the middle of one run.

// File: rtl/dwt_pkg.sv
package dwt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_DRAIN,
    ST_WRITE,
    ST_FIN
  } dwtState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic rdEn;      // engine owns the RAM read port this cycle
    logic capValid;  // ramQ holds the sample numbered capIdx
    logic wrEn;      // write the de-interleaved sample at stepIdx
  } dwtStrobe_t;

endpackage

// File: rtl/dwt_lift53.sv
// One lifting step pair of the reversible 5/3 filter, combinational.
module dwt_lift53 #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] evenL,
  input  logic [DATA_W-1:0] oddM,
  input  logic [DATA_W-1:0] evenR,
  input  logic [DATA_W-1:0] dPrev,
  input  logic              firstPair,
  output logic [DATA_W-1:0] detail,
  output logic [DATA_W-1:0] smooth
);
  localparam int EXT_W = DATA_W + 3;

  logic signed [EXT_W-1:0] aExt, bExt, cExt, pExt, dExt, sExt;

  always_comb begin
    aExt = EXT_W'($signed(evenL));
    bExt = EXT_W'($signed(oddM));
    cExt = EXT_W'($signed(evenR));
    dExt = bExt - ((aExt + cExt) >>> 1);
    pExt = firstPair ? dExt : EXT_W'($signed(dPrev));
    sExt = aExt + ((pExt + dExt + EXT_W'(2)) >>> 2);
    detail = dExt[DATA_W-1:0];
    smooth = sExt[DATA_W-1:0];
  end
endmodule

// File: rtl/dwt_ctrl.sv
// Sequencer: level -> pass (rows, columns) -> line -> read/drain/write.
module dwt_ctrl
  import dwt_pkg::*;
#(
  parameter int TILE   = 32,
  parameter int LEVELS = 3,
  localparam int IDX_W  = $clog2(TILE),
  localparam int ADDR_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output dwtStrobe_t        stb,
  output logic [ADDR_W-1:0] engAddr,
  output logic [IDX_W-1:0]  capIdx,
  output logic [IDX_W-1:0]  stepIdx,
  output logic [IDX_W:0]    lineLen,
  output logic              busy,
  output logic              done
);
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

  dwtState_e        state;
  logic [LVL_W-1:0] level;
  logic             colPass;
  logic [IDX_W-1:0] line;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             capValidQ;
  logic [IDX_W-1:0] capIdxQ;

  always_comb begin
    lineLen = (IDX_W + 1)'(TILE) >> level;
    lastIdx = IDX_W'(lineLen - 1'b1);
    engAddr = colPass ? {idx, line} : {line, idx};
    stb.rdEn     = (state == ST_READ);
    stb.capValid = capValidQ;
    stb.wrEn     = (state == ST_WRITE);
    capIdx  = capIdxQ;
    stepIdx = idx;
    busy = (state == ST_READ) || (state == ST_DRAIN) || (state == ST_WRITE);
    done = (state == ST_FIN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      level     <= '0;
      colPass   <= 1'b0;
      line      <= '0;
      idx       <= '0;
      capValidQ <= 1'b0;
      capIdxQ   <= '0;
    end else begin
      capValidQ <= (state == ST_READ);
      capIdxQ   <= idx;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_READ;
            level   <= '0;
            colPass <= 1'b0;
            line    <= '0;
            idx     <= '0;
          end
        end
        ST_READ: begin
          if (idx == lastIdx) begin
            idx   <= '0;
            state <= ST_DRAIN;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_DRAIN: state <= ST_WRITE;
        ST_WRITE: begin
          if (idx == lastIdx) begin
            idx <= '0;
            if (line != lastIdx) begin
              line  <= line + 1'b1;
              state <= ST_READ;
            end else if (!colPass) begin
              colPass <= 1'b1;
              line    <= '0;
              state   <= ST_READ;
            end else if (level != LVL_W'(LEVELS - 1)) begin
              level   <= level + 1'b1;
              colPass <= 1'b0;
              line    <= '0;
              state   <= ST_READ;
            end else begin
              state <= ST_FIN;
            end
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dwt_datapath.sv
// Tile RAM, line buffer, streaming lifting filter and de-interleave write-back.
module dwt_datapath
  import dwt_pkg::*;
#(
  parameter int TILE   = 32,
  parameter int DATA_W = 16,
  localparam int IDX_W  = $clog2(TILE),
  localparam int ADDR_W = 2 * IDX_W,
  localparam int HALF_W = IDX_W - 1
) (
  input  logic              clk,
  input  dwtStrobe_t        stb,
  input  logic [ADDR_W-1:0] engAddr,
  input  logic [IDX_W-1:0]  capIdx,
  input  logic [IDX_W-1:0]  stepIdx,
  input  logic [IDX_W:0]    lineLen,
  input  logic              busy,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic [ADDR_W-1:0] extAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem     [TILE*TILE];
  logic [DATA_W-1:0] lineBuf [TILE];
  logic [DATA_W-1:0] lowBuf  [TILE/2];
  logic [DATA_W-1:0] highBuf [TILE/2];

  logic [DATA_W-1:0] ramQ, dPrev, liftD, liftS, wrData;
  logic [DATA_W-1:0] tapA, tapB, tapC;
  logic [IDX_W-1:0]  lastIdx, tapAIdx, tapBIdx, halfLen;
  logic [HALF_W-1:0] pairIdx, bandIdx;
  logic              capLast, fire, inLow;

  // Filter stage: fires on every even sample from index 2 on and on the last sample
  always_comb begin
    lastIdx = IDX_W'(lineLen - 1'b1);
    capLast = (capIdx == lastIdx);
    fire    = stb.capValid && (capLast || (!capIdx[0] && (capIdx != '0)));
    tapAIdx = capLast ? capIdx - 1'b1 : capIdx - IDX_W'(2);
    tapBIdx = capIdx - 1'b1;
    tapA    = lineBuf[tapAIdx];
    tapB    = capLast ? ramQ : lineBuf[tapBIdx];
    tapC    = capLast ? lineBuf[tapAIdx] : ramQ;  // mirror at the far border
    pairIdx = HALF_W'(tapAIdx >> 1);
  end

  dwt_lift53 #(.DATA_W(DATA_W)) i_lift (
    .evenL    (tapA),
    .oddM     (tapB),
    .evenR    (tapC),
    .dPrev    (dPrev),
    .firstPair(pairIdx == '0),
    .detail   (liftD),
    .smooth   (liftS)
  );

  // De-interleave stage: lows first, highs after
  always_comb begin
    halfLen = IDX_W'(lineLen >> 1);
    inLow   = (stepIdx < halfLen);
    bandIdx = inLow ? HALF_W'(stepIdx) : HALF_W'(stepIdx - halfLen);
    wrData  = inLow ? lowBuf[bandIdx] : highBuf[bandIdx];
  end

  always_ff @(posedge clk) begin
    if (stb.wrEn) begin
      mem[engAddr] <= wrData;
    end else if (loadEn && !busy) begin
      mem[loadAddr] <= loadData;
    end
    ramQ <= mem[stb.rdEn ? engAddr : extAddr];
    if (stb.capValid) begin
      lineBuf[capIdx] <= ramQ;
    end
    if (fire) begin
      lowBuf[pairIdx]  <= liftS;
      highBuf[pairIdx] <= liftD;
      dPrev            <= liftD;
    end
  end

  assign rdData = ramQ;
endmodule

// File: rtl/dwt_tile_engine.sv
module dwt_tile_engine
  import dwt_pkg::*;
#(
  parameter int TILE   = 32,
  parameter int DATA_W = 16,
  parameter int LEVELS = 3,
  localparam int IDX_W  = $clog2(TILE),
  localparam int ADDR_W = 2 * IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [DATA_W-1:0] loadData,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  dwtStrobe_t        stb;
  logic [ADDR_W-1:0] engAddr;
  logic [IDX_W-1:0]  capIdx, stepIdx;
  logic [IDX_W:0]    lineLen;

  dwt_ctrl #(.TILE(TILE), .LEVELS(LEVELS)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .stb    (stb),
    .engAddr(engAddr),
    .capIdx (capIdx),
    .stepIdx(stepIdx),
    .lineLen(lineLen),
    .busy   (busy),
    .done   (done)
  );

  dwt_datapath #(.TILE(TILE), .DATA_W(DATA_W)) i_dp (
    .clk     (clk),
    .stb     (stb),
    .engAddr (engAddr),
    .capIdx  (capIdx),
    .stepIdx (stepIdx),
    .lineLen (lineLen),
    .busy    (busy),
    .loadEn  (loadEn),
    .loadAddr(loadAddr),
    .loadData(loadData),
    .extAddr (rdAddr),
    .rdData  (rdData)
  );
endmodule

// File: rtl/dwt_tile_checker.sv
module dwt_tile_checker (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done
);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));

  p_fall_into_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  p_start_launch_r3: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

  p_rise_from_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
endmodule

bind dwt_tile_engine dwt_tile_checker i_chk (
  .clk  (clk),
  .rstN (rstN),
  .start(start),
  .busy (busy),
  .done (done)
);

// File: tb/test_dwt_tile_engine.sv
module test_dwt_tile_engine;
  localparam int TILE   = 32;
  localparam int DW     = 16;
  localparam int LEVELS = 3;
  localparam int AW     = 2 * $clog2(TILE);
  localparam int NPIX   = TILE * TILE;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          loadEn = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic [DW-1:0] loadData = '0;
  logic          start = 1'b0;
  logic          busy, done;
  logic [AW-1:0] rdAddr = '0;
  logic [DW-1:0] rdData;

  int checks = 0;
  int errors = 0;
  int orig [NPIX];
  int mdl  [NPIX];
  int got  [NPIX];
  int inv  [NPIX];

  always #10 clk = ~clk;

  dwt_tile_engine #(.TILE(TILE), .DATA_W(DW), .LEVELS(LEVELS)) i_dwt_tile_engine (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .start(start), .busy(busy), .done(done), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Forward lifting on one line of the model, lows then highs
  task automatic fwdLine(input int base, input int stride, input int n);
    int x[TILE];
    int d[TILE/2];
    int s[TILE/2];
    for (int i = 0; i < n; i++) x[i] = mdl[base + i*stride];
    for (int m = 0; m < n/2; m++) begin
      int c = (2*m+2 < n) ? x[2*m+2] : x[n-2];
      d[m] = x[2*m+1] - ((x[2*m] + c) >>> 1);
    end
    for (int m = 0; m < n/2; m++) begin
      int p = (m == 0) ? d[0] : d[m-1];
      s[m] = x[2*m] + ((p + d[m] + 2) >>> 2);
    end
    for (int m = 0; m < n/2; m++) begin
      mdl[base + m*stride]         = s[m];
      mdl[base + (m + n/2)*stride] = d[m];
    end
  endtask

  // Inverse lifting on one line of inv[]
  task automatic invLine(input int base, input int stride, input int n);
    int x[TILE];
    int d[TILE/2];
    int s[TILE/2];
    for (int m = 0; m < n/2; m++) begin
      s[m] = inv[base + m*stride];
      d[m] = inv[base + (m + n/2)*stride];
    end
    for (int m = 0; m < n/2; m++) begin
      int p = (m == 0) ? d[0] : d[m-1];
      x[2*m] = s[m] - ((p + d[m] + 2) >>> 2);
    end
    for (int m = 0; m < n/2; m++) begin
      int c = (2*m+2 < n) ? x[2*m+2] : x[n-2];
      x[2*m+1] = d[m] + ((x[2*m] + c) >>> 1);
    end
    for (int i = 0; i < n; i++) inv[base + i*stride] = x[i];
  endtask

  task automatic buildModel();
    for (int i = 0; i < NPIX; i++) mdl[i] = orig[i];
    for (int lv = 0; lv < LEVELS; lv++) begin
      int n = TILE >> lv;
      for (int r = 0; r < n; r++) fwdLine(r*TILE, 1, n);
      for (int c = 0; c < n; c++) fwdLine(c, TILE, n);
    end
  endtask

  task automatic loadTile();
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = AW'(i); loadData = DW'(orig[i]);
    end
    @(negedge clk);
    loadEn = 1'b0;
  endtask

  task automatic readTile();
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      rdAddr = AW'(i);
      @(negedge clk);
      got[i] = int'($signed(rdData));
    end
  endtask

  function automatic int expectedCycles();
    int total = 0;
    for (int lv = 0; lv < LEVELS; lv++) begin
      int n = TILE >> lv;
      total += 2*n*(2*n+1);
    end
    return total;
  endfunction

  // Runs one transform, optionally injecting stray start/load strobes mid-run
  task automatic runTile(input string name, input bit disturb);
    int cyc = 0;
    int doneCnt = 0;
    loadTile();
    buildModel();
    @(negedge clk);
    start = 1'b1;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      start = 1'b0;
      loadEn = 1'b0;
      if (busy) cyc++;
      if (done) begin
        doneCnt++;
        break;
      end
      if (disturb && cyc == 100) begin
        start = 1'b1;
        loadEn = 1'b1; loadAddr = '0; loadData = DW'(12345);
      end
    end
    @(negedge clk);
    chk(doneCnt == 1, {"R7 done pulse seen ", name}, doneCnt, 1);
    chk(!done && !busy, {"R7 done lasts one cycle ", name}, int'(done), 0);
    chk(cyc == expectedCycles(), {"R10 busy length ", name}, cyc, expectedCycles());
    if (disturb) chk(cyc == expectedCycles(), "R3 stray start ignored", cyc, expectedCycles());
    readTile();
    for (int i = 0; i < NPIX; i++)
      chk(got[i] == mdl[i],
          disturb ? {"R9 R4/R5/R6 coefficient ", name} : {"R4/R5/R6 coefficient ", name},
          got[i], mdl[i]);
    for (int i = 0; i < NPIX; i++) inv[i] = got[i];
    for (int lv = LEVELS-1; lv >= 0; lv--) begin
      int n = TILE >> lv;
      for (int c = 0; c < n; c++) invLine(c, TILE, n);
      for (int r = 0; r < n; r++) invLine(r*TILE, 1, n);
    end
    for (int i = 0; i < NPIX; i++)
      chk(inv[i] == orig[i], {"R8 inverse restores input ", name}, inv[i], orig[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(!busy, "R1 busy low in reset", int'(busy), 0);
    chk(!done, "R1 done low in reset", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R1 idle after reset", int'(busy), 0);

    // R2: load and read back while idle
    for (int i = 0; i < NPIX; i++) orig[i] = (i * 37) % 1999 - 999;
    loadTile();
    for (int j = 0; j < 8; j++) begin
      int a = (j * 131 + 7) % NPIX;
      @(negedge clk);
      rdAddr = AW'(a);
      @(negedge clk);
      chk(int'($signed(rdData)) == orig[a], "R2 load then readback",
          int'($signed(rdData)), orig[a]);
    end

    // Random tile
    for (int i = 0; i < NPIX; i++) orig[i] = int'($urandom_range(2000)) - 1000;
    runTile("random", 1'b0);

    // Constant tile
    for (int i = 0; i < NPIX; i++) orig[i] = 777;
    runTile("constant", 1'b0);

    // Full-swing checkerboard with stray strobes mid-run
    for (int i = 0; i < NPIX; i++)
      orig[i] = (((i / TILE) + (i % TILE)) % 2 == 0) ? 1000 : -1000;
    runTile("checker", 1'b1);

    // Impulse at the far corner exercises the border mirror
    for (int i = 0; i < NPIX; i++) orig[i] = 0;
    orig[NPIX-1] = -1000;
    orig[TILE-1] = 1000;
    runTile("impulse", 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule